// File: doc/BRIEF.md
# Banked Effective Address Generator

This block turns an addressing-mode code and the operand bytes of an instruction into the 24-bit effective address that an 8/16-bit CPU with banked memory places on its bus. It uses the live register state: the X and Y index registers, the index-width flag, a movable 16-bit direct page base, the stack pointer, the data and program bank bytes, the current program counter and the emulation flag. Alongside the address it raises a page-cross flag, which the sequencer uses to decide whether an indexed access needs its extra cycle.

The address math is combinational. A parameter can add one output register, with synchronous reset, so that the result can be timed as its own pipeline stage. Operand byte 0 is the first byte after the opcode and sits in `opnd_i[7:0]`. Byte 1 sits in `[15:8]`, and byte 2 (the bank byte of a long operand) sits in `[23:16]`. Indirect pointer fetches and bus sequencing are handled elsewhere.

Top module: `banked_ea_gen`

## Requirements
- R1: Mode code 0 (direct) yields {0x00, (dp + byte0) mod 2^16}.
- R2: Mode codes 1 (direct,X) and 2 (direct,Y), outside the R9 case, yield {0x00, (dp + byte0 + index) mod 2^16}. Every direct and stack-relative result has bank byte 0x00.
- R3: Mode code 3 (absolute) yields {data bank, byte1, byte0}.
- R4: Mode codes 4 (absolute,X) and 5 (absolute,Y) yield ({data bank, byte1, byte0} + index) mod 2^24, so a carry out of bit 15 reaches the bank byte.
- R5: Mode code 6 (long) yields the 24-bit operand as given. Mode code 7 (long,X) yields (operand + X) mod 2^24. Y is never used by code 7.
- R6: When idx8_i is 1 or emu_i is 1, only the low byte of X or Y is added, extended with zeros. Otherwise all 16 bits are added.
- R7: Mode code 9 yields {program bank, (pc + sign-extended byte0) mod 2^16}. Mode code 10 yields {program bank, (pc + {byte1, byte0}) mod 2^16}. The bank byte is never changed by a carry.
- R8: Mode code 8 (stack relative) yields {0x00, (sp + byte0) mod 2^16} when emu_i is 0. When emu_i is 1 it yields {0x00, 0x01, (sp[7:0] + byte0) mod 2^8}.
- R9: In modes 1 and 2 with emu_i = 1 and dp[7:0] = 0, the result is {0x00, dp[15:8], (byte0 + index low byte) mod 2^8}, which wraps inside the page.
- R10: In modes 1, 2, 4, 5 and 7, pgx_o is 1 exactly when bits 15:8 of the result differ from bits 15:8 of the unindexed base. That base is dp + byte0 for the direct modes and {byte1, byte0} otherwise. In every other mode pgx_o is 0.
- R11: Mode codes 11 to 15 yield address 0 and pgx_o 0.
- R12: With PIPE_STAGE = 1 the outputs show the inputs of the previous rising edge, and a cycle with rst high clears them to zero. With PIPE_STAGE = 0 the outputs follow the inputs directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 4 | Addressing-mode code |
| opnd_i | input | 24 | Operand bytes: byte0 in [7:0], byte1 in [15:8], byte2 in [23:16] |
| idx_x_i | input | 16 | X index register |
| idx_y_i | input | 16 | Y index register |
| idx8_i | input | 1 | 1 selects 8-bit index width |
| dp_base_i | input | 16 | Direct page base register |
| sp_i | input | 16 | Stack pointer |
| dbank_i | input | 8 | Data bank byte |
| pbank_i | input | 8 | Program bank byte |
| pc_i | input | 16 | Program counter of the next instruction |
| emu_i | input | 1 | Emulation mode flag |
| ea_o | output | 24 | Effective address |
| pgx_o | output | 1 | Index add changed the page |

## Verification
On every cycle, the assertions check the bank byte each mode family must carry: zero for direct and stack-relative modes, the data bank for absolute, and the program bank for branches. They also check that long mode passes the operand through unchanged, that the emulation stack stays in page 1, and that the page-cross flag stays low outside the indexed modes. The bench's directed scenarios are needed for the arithmetic itself. These cover the 16-bit wrap of direct page sums, the carry of absolute indexed and long indexed sums into the bank byte, and narrowing of the index by width flag or emulation. They also cover in-page wrap when the direct page low byte is zero, backward and forward branches that wrap inside the bank, reserved codes, and the reset value of the output register.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;

    localparam int BANK_W = 8;
    localparam int OFS_W  = 16;
    localparam int ADDR_W = BANK_W + OFS_W;
    localparam int PAGE_W = OFS_W / 2;

    typedef enum logic [3:0] {
        AM_DIR   = 4'd0,
        AM_DIR_X = 4'd1,
        AM_DIR_Y = 4'd2,
        AM_ABS   = 4'd3,
        AM_ABS_X = 4'd4,
        AM_ABS_Y = 4'd5,
        AM_LONG  = 4'd6,
        AM_LONG_X= 4'd7,
        AM_STK   = 4'd8,
        AM_BR8   = 4'd9,
        AM_BR16  = 4'd10
    } am_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              pgx;
    } ea_res_t;

    // Narrow an index register to its low byte when the 8-bit width applies.
    function automatic logic [OFS_W-1:0] pick_index(input logic [OFS_W-1:0] r,
                                                    input logic narrow);
        return narrow ? {{(OFS_W-PAGE_W){1'b0}}, r[PAGE_W-1:0]} : r;
    endfunction

    // True when the page part of two in-bank offsets differs.
    function automatic logic crossed(input logic [OFS_W-1:0] base,
                                     input logic [OFS_W-1:0] res);
        return base[OFS_W-1:PAGE_W] != res[OFS_W-1:PAGE_W];
    endfunction

endpackage

// File: rtl/ea_direct_unit.sv
module ea_direct_unit
    import ea_gen_pkg::*;
(
    input  logic [OFS_W-1:0]  dp,
    input  logic [PAGE_W-1:0] off,
    input  logic [OFS_W-1:0]  idx,
    input  logic              use_idx,
    input  logic              emu,
    output ea_res_t           res
);
    logic [OFS_W-1:0]  base;
    logic [OFS_W-1:0]  full;
    logic [PAGE_W-1:0] page_lo;
    logic              wrap;
    logic [OFS_W-1:0]  ofs;

    always_comb begin
        base    = dp + {{(OFS_W-PAGE_W){1'b0}}, off};
        full    = base + idx;
        page_lo = off + idx[PAGE_W-1:0];
        wrap    = use_idx && emu && (dp[PAGE_W-1:0] == '0);
        if (!use_idx)
            ofs = base;
        else if (wrap)
            ofs = {dp[OFS_W-1:PAGE_W], page_lo};
        else
            ofs = full;
        res.addr = {{BANK_W{1'b0}}, ofs};
        res.pgx  = use_idx && crossed(base, ofs);
    end
endmodule

// File: rtl/ea_bank_unit.sv
module ea_bank_unit
    import ea_gen_pkg::*;
(
    input  logic [BANK_W-1:0] bank,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [OFS_W-1:0]  idx,
    input  logic              use_idx,
    output ea_res_t           res
);
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] sum;

    always_comb begin
        base     = {bank, ofs};
        sum      = base + {{BANK_W{1'b0}}, idx};
        res.addr = use_idx ? sum : base;
        res.pgx  = use_idx && crossed(ofs, sum[OFS_W-1:0]);
    end
endmodule

// File: rtl/ea_stack_unit.sv
module ea_stack_unit
    import ea_gen_pkg::*;
(
    input  logic [OFS_W-1:0]  sp,
    input  logic [PAGE_W-1:0] off,
    input  logic              emu,
    output ea_res_t           res
);
    localparam logic [PAGE_W-1:0] EMU_PAGE = PAGE_W'(1);

    logic [OFS_W-1:0]  wide;
    logic [PAGE_W-1:0] low;

    always_comb begin
        wide     = sp + {{(OFS_W-PAGE_W){1'b0}}, off};
        low      = sp[PAGE_W-1:0] + off;
        res.addr = {{BANK_W{1'b0}}, (emu ? {EMU_PAGE, low} : wide)};
        res.pgx  = 1'b0;
    end
endmodule

// File: rtl/ea_branch_unit.sv
module ea_branch_unit
    import ea_gen_pkg::*;
(
    input  logic [OFS_W-1:0]  pc,
    input  logic [BANK_W-1:0] pbank,
    input  logic [OFS_W-1:0]  disp_raw,
    input  logic              long_form,
    output ea_res_t           res
);
    logic [OFS_W-1:0] disp;
    logic [OFS_W-1:0] tgt;

    always_comb begin
        disp     = long_form ? disp_raw
                             : {{(OFS_W-PAGE_W){disp_raw[PAGE_W-1]}}, disp_raw[PAGE_W-1:0]};
        tgt      = pc + disp;
        res.addr = {pbank, tgt};
        res.pgx  = 1'b0;
    end
endmodule

// File: rtl/banked_ea_gen.sv
module banked_ea_gen
    import ea_gen_pkg::*;
#(
    parameter int PIPE_STAGE = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  mode_i,
    input  logic [23:0] opnd_i,
    input  logic [15:0] idx_x_i,
    input  logic [15:0] idx_y_i,
    input  logic        idx8_i,
    input  logic [15:0] dp_base_i,
    input  logic [15:0] sp_i,
    input  logic [7:0]  dbank_i,
    input  logic [7:0]  pbank_i,
    input  logic [15:0] pc_i,
    input  logic        emu_i,
    output logic [23:0] ea_o,
    output logic        pgx_o
);
    logic             narrow;
    logic             sel_y;
    logic             dir_idx;
    logic             bank_idx;
    logic             is_long;
    logic [OFS_W-1:0] x_n;
    logic [OFS_W-1:0] y_n;
    logic [OFS_W-1:0] idx_sel;
    logic [BANK_W-1:0] bank_sel;
    ea_res_t          r_dir, r_bank, r_stk, r_br, nxt;

    assign narrow   = idx8_i | emu_i;
    assign x_n      = pick_index(idx_x_i, narrow);
    assign y_n      = pick_index(idx_y_i, narrow);
    assign sel_y    = (mode_i == AM_DIR_Y) || (mode_i == AM_ABS_Y);
    assign idx_sel  = sel_y ? y_n : x_n;
    assign dir_idx  = (mode_i == AM_DIR_X) || (mode_i == AM_DIR_Y);
    assign bank_idx = (mode_i == AM_ABS_X) || (mode_i == AM_ABS_Y) || (mode_i == AM_LONG_X);
    assign is_long  = (mode_i == AM_LONG) || (mode_i == AM_LONG_X);
    assign bank_sel = is_long ? opnd_i[ADDR_W-1:OFS_W] : dbank_i;

    ea_direct_unit u_dir (
        .dp      (dp_base_i),
        .off     (opnd_i[PAGE_W-1:0]),
        .idx     (idx_sel),
        .use_idx (dir_idx),
        .emu     (emu_i),
        .res     (r_dir)
    );

    ea_bank_unit u_bank (
        .bank    (bank_sel),
        .ofs     (opnd_i[OFS_W-1:0]),
        .idx     (idx_sel),
        .use_idx (bank_idx),
        .res     (r_bank)
    );

    ea_stack_unit u_stk (
        .sp  (sp_i),
        .off (opnd_i[PAGE_W-1:0]),
        .emu (emu_i),
        .res (r_stk)
    );

    ea_branch_unit u_br (
        .pc        (pc_i),
        .pbank     (pbank_i),
        .disp_raw  (opnd_i[OFS_W-1:0]),
        .long_form (mode_i == AM_BR16),
        .res       (r_br)
    );

    always_comb begin
        case (mode_i)
            AM_DIR, AM_DIR_X, AM_DIR_Y:                    nxt = r_dir;
            AM_ABS, AM_ABS_X, AM_ABS_Y, AM_LONG, AM_LONG_X: nxt = r_bank;
            AM_STK:                                        nxt = r_stk;
            AM_BR8, AM_BR16:                               nxt = r_br;
            default:                                       nxt = '0;
        endcase
    end

    generate
        if (PIPE_STAGE != 0) begin : g_reg
            ea_res_t res_q;
            always_ff @(posedge clk) begin
                if (rst) res_q <= '0;
                else     res_q <= nxt;
            end
            assign ea_o  = res_q.addr;
            assign pgx_o = res_q.pgx;
        end else begin : g_comb
            assign ea_o  = nxt.addr;
            assign pgx_o = nxt.pgx;
        end
    endgenerate
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
    parameter int PIPE_STAGE = 1
) (
    input logic        clk,
    input logic        rst,
    input logic [3:0]  mode_i,
    input logic [23:0] opnd_i,
    input logic [15:0] sp_i,
    input logic [7:0]  dbank_i,
    input logic [7:0]  pbank_i,
    input logic        emu_i,
    input logic [23:0] ea_o,
    input logic        pgx_o
);
    logic [3:0]  m_q;
    logic [23:0] op_q;
    logic [7:0]  db_q, pb_q;
    logic        emu_q;
    logic        armed;
    logic [15:0] sp_unused;

    assign sp_unused = sp_i;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    generate
        if (PIPE_STAGE != 0) begin : g_q
            always_ff @(posedge clk) begin
                m_q   <= mode_i;
                op_q  <= opnd_i;
                db_q  <= dbank_i;
                pb_q  <= pbank_i;
                emu_q <= emu_i;
            end
        end else begin : g_d
            assign m_q   = mode_i;
            assign op_q  = opnd_i;
            assign db_q  = dbank_i;
            assign pb_q  = pbank_i;
            assign emu_q = emu_i;
        end
    endgenerate

    a_r2_bank_zero: assert property (@(posedge clk) disable iff (rst)
        (armed && (m_q == 4'd0 || m_q == 4'd1 || m_q == 4'd2 || m_q == 4'd8))
        |-> (ea_o[23:16] == 8'h00));

    a_r3_data_bank: assert property (@(posedge clk) disable iff (rst)
        (armed && m_q == 4'd3) |-> (ea_o == {db_q, op_q[15:0]}));

    a_r5_long_pass: assert property (@(posedge clk) disable iff (rst)
        (armed && m_q == 4'd6) |-> (ea_o == op_q));

    a_r7_prog_bank: assert property (@(posedge clk) disable iff (rst)
        (armed && (m_q == 4'd9 || m_q == 4'd10)) |-> (ea_o[23:16] == pb_q));

    a_r8_emu_page1: assert property (@(posedge clk) disable iff (rst)
        (armed && m_q == 4'd8 && emu_q) |-> (ea_o[15:8] == 8'h01));

    a_r10_no_cross: assert property (@(posedge clk) disable iff (rst)
        (armed && !(m_q == 4'd1 || m_q == 4'd2 || m_q == 4'd4 || m_q == 4'd5 || m_q == 4'd7))
        |-> !pgx_o);
endmodule

bind banked_ea_gen ea_gen_chk #(.PIPE_STAGE(PIPE_STAGE)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .mode_i  (mode_i),
    .opnd_i  (opnd_i),
    .sp_i    (sp_i),
    .dbank_i (dbank_i),
    .pbank_i (pbank_i),
    .emu_i   (emu_i),
    .ea_o    (ea_o),
    .pgx_o   (pgx_o)
);

// File: tb/sim_banked_ea_gen.sv
module sim_banked_ea_gen;
    localparam int PIPE = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  mode = '0;
    logic [23:0] opnd = '0;
    logic [15:0] ix = '0, iy = '0, dp = '0, sp = '0, pc = '0;
    logic        n8 = 1'b0, emu = 1'b0;
    logic [7:0]  db = '0, pb = '0;
    logic [23:0] ea;
    logic        pgx;

    int total = 0;
    int bad = 0;
    logic [24:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    banked_ea_gen #(.PIPE_STAGE(PIPE)) u0 (
        .clk(clk), .rst(rst), .mode_i(mode), .opnd_i(opnd),
        .idx_x_i(ix), .idx_y_i(iy), .idx8_i(n8), .dp_base_i(dp),
        .sp_i(sp), .dbank_i(db), .pbank_i(pb), .pc_i(pc), .emu_i(emu),
        .ea_o(ea), .pgx_o(pgx)
    );

    // Reference model written from the requirement text: {pgx, address}.
    function automatic logic [24:0] model(
        input logic [3:0] m, input logic [23:0] op, input logic [15:0] x,
        input logic [15:0] y, input logic narrow8, input logic [15:0] d,
        input logic [15:0] s, input logic [7:0] dbk, input logic [7:0] pbk,
        input logic [15:0] p, input logic e);
        logic [15:0] xi, yi, ii, base16, r16;
        logic [23:0] a;
        logic [7:0]  lo;
        logic        f;
        xi = (narrow8 || e) ? {8'h00, x[7:0]} : x;
        yi = (narrow8 || e) ? {8'h00, y[7:0]} : y;
        f = 1'b0;
        a = '0;
        case (m)
            4'd0: begin base16 = d + {8'h00, op[7:0]}; a = {8'h00, base16}; end
            4'd1, 4'd2: begin
                ii = (m == 4'd1) ? xi : yi;
                base16 = d + {8'h00, op[7:0]};
                if (e && d[7:0] == 8'h00) begin
                    lo = op[7:0] + ii[7:0];
                    r16 = {d[15:8], lo};
                end else r16 = base16 + ii;
                a = {8'h00, r16};
                f = (r16[15:8] != base16[15:8]);
            end
            4'd3: a = {dbk, op[15:0]};
            4'd4, 4'd5: begin
                ii = (m == 4'd4) ? xi : yi;
                a = {dbk, op[15:0]} + {8'h00, ii};
                f = (a[15:8] != op[15:8]);
            end
            4'd6: a = op;
            4'd7: begin a = op + {8'h00, xi}; f = (a[15:8] != op[15:8]); end
            4'd8: begin
                if (e) begin lo = s[7:0] + op[7:0]; a = {16'h0001, lo}; end
                else begin r16 = s + {8'h00, op[7:0]}; a = {8'h00, r16}; end
            end
            4'd9:  begin r16 = p + {{8{op[7]}}, op[7:0]}; a = {pbk, r16}; end
            4'd10: begin r16 = p + op[15:0]; a = {pbk, r16}; end
            default: begin a = '0; f = 1'b0; end
        endcase
        return {f, a};
    endfunction

    task automatic drive(input logic [3:0] m, input logic [23:0] op,
                         input logic [15:0] x, input logic [15:0] y, input logic w8,
                         input logic [15:0] d, input logic [15:0] s,
                         input logic [7:0] dbk, input logic [7:0] pbk,
                         input logic [15:0] p, input logic e, input string tag);
        @(negedge clk);
        mode = m; opnd = op; ix = x; iy = y; n8 = w8; dp = d; sp = s;
        db = dbk; pb = pbk; pc = p; emu = e;
        exp_q.push_back(model(m, op, x, y, w8, d, s, dbk, pbk, p, e));
        tag_q.push_back(tag);
    endtask

    task automatic check_lit(input string tag, input logic [24:0] got, input logic [24:0] want);
        total++;
        if (got !== want) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, want);
        end
    endtask

    // Monitor: compares each result one edge after its stimulus.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [24:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check_lit(t, {pgx, ea}, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R12: reset clears the registered output even with live inputs.
        mode = 4'd6; opnd = 24'h123456;
        repeat (3) @(posedge clk);
        #1;
        check_lit("R12 reset", {pgx, ea}, PIPE != 0 ? 25'h0 : {1'b0, 24'h123456});
        @(negedge clk); rst = 1'b0;

        // R1 direct page, plain and wrapping at 64K
        drive(4'd0, 24'h000056, 0, 0, 0, 16'h1234, 0, 8'h7E, 0, 0, 0, "R1 direct");
        drive(4'd0, 24'h000020, 0, 0, 0, 16'hFFF0, 0, 8'h7E, 0, 0, 0, "R1 direct wrap");
        // R2 / R10 direct indexed, full-width index crossing a page
        drive(4'd1, 24'h000010, 16'h0102, 0, 0, 16'h2000, 0, 8'h33, 0, 0, 0, "R2 dir,X cross R10");
        drive(4'd2, 24'h000004, 0, 16'h0003, 0, 16'h2000, 0, 8'h33, 0, 0, 0, "R2 dir,Y");
        // R6 narrowing by width flag and by emulation
        drive(4'd1, 24'h000010, 16'h0102, 0, 1, 16'h2000, 0, 0, 0, 0, 0, "R6 8-bit index");
        drive(4'd1, 24'h000010, 16'h01FF, 0, 0, 16'h2001, 0, 0, 0, 0, 1, "R6 emu narrows");
        // R9 emulation in-page wrap versus native carry
        drive(4'd1, 24'h0000F0, 16'h0020, 0, 0, 16'h3000, 0, 0, 0, 0, 1, "R9 emu page wrap");
        drive(4'd2, 24'h0000F0, 0, 16'h0020, 1, 16'h3000, 0, 0, 0, 0, 0, "R9 native carries");
        // R3 absolute uses data bank
        drive(4'd3, 24'hAABEEF, 0, 0, 0, 0, 0, 8'h7E, 8'h11, 0, 0, "R3 absolute");
        // R4 absolute indexed with bank carry
        drive(4'd4, 24'h00FFF0, 16'h0020, 0, 0, 0, 0, 8'h01, 0, 0, 0, "R4 abs,X bank carry");
        drive(4'd5, 24'h001234, 16'h9999, 16'h1000, 0, 0, 0, 8'h05, 0, 0, 0, "R4 abs,Y");
        // R5 long and long indexed
        drive(4'd6, 24'h0445F2, 16'hFFFF, 0, 0, 0, 0, 8'h22, 0, 0, 0, "R5 long");
        drive(4'd7, 24'h03412F, 16'h0005, 16'h7777, 0, 0, 0, 8'h22, 0, 0, 0, "R5 long,X");
        drive(4'd7, 24'h12FFFF, 16'h0001, 0, 0, 0, 0, 8'h22, 0, 0, 0, "R5 long,X carry");
        // R7 branches wrap inside the program bank
        drive(4'd9, 24'h0000FE, 0, 0, 0, 0, 0, 0, 8'h05, 16'h8000, 0, "R7 short back");
        drive(4'd9, 24'h000020, 0, 0, 0, 0, 0, 0, 8'h05, 16'hFFF0, 0, "R7 short wrap");
        drive(4'd10, 24'h002000, 0, 0, 0, 0, 0, 0, 8'h05, 16'hF000, 0, "R7 long wrap");
        // R8 stack relative native and emulation
        drive(4'd8, 24'h000020, 0, 0, 0, 0, 16'h01F0, 0, 0, 0, 0, "R8 native");
        drive(4'd8, 24'h000020, 0, 0, 0, 0, 16'h1FF0, 0, 0, 0, 1, "R8 emu page1");
        // R11 reserved codes
        drive(4'd11, 24'hFFFFFF, 16'hFFFF, 16'hFFFF, 0, 16'hFFFF, 16'hFFFF, 8'hFF, 8'hFF, 16'hFFFF, 0, "R11 reserved");
        drive(4'd15, 24'h123456, 16'h1, 16'h1, 0, 16'h1, 16'h1, 8'h1, 8'h1, 16'h1, 1, "R11 reserved");

        repeat (3) @(posedge clk);
        #2;
        // R1 literal cross-check on the model itself
        check_lit("R1 model", model(4'd0, 24'h56, 0, 0, 0, 16'h1234, 0, 0, 0, 0, 0), 25'h000128A);
        check_lit("R9 model", model(4'd1, 24'hF0, 16'h20, 0, 0, 16'h3000, 0, 0, 0, 0, 1), 25'h0003010);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule